// File: doc/BRIEF.md
# Windowed Active Power Overload Trip

This block watches a single-phase load through a pair of 12-bit unsigned converter readings, one for voltage and one for current. It generates the sampling strobe itself from a clock divider and collects each strobed pair into a fixed window. At the default settings a 16 MHz clock and a division of 8000 give 2 kHz sampling, and 200 pairs give a 100 ms window. Samples are written into two alternating banks, so acquisition never pauses while the previous window is evaluated.

When a window closes, the block takes the floor of each channel's window average as that channel's DC bias. It then walks the stored window once, subtracting the bias from every sample before multiplying, and sums the signed products. The sum is divided by the window length, truncating toward zero, and multiplied by a fixed-point scale (Q8.8 by default) to give active power. Power is published with a one-cycle valid pulse. A result above the programmable limit latches a breaker-style trip that stays set until a synchronous clear or a reset. The limit is an input, so the 15 W default is a value chosen by the integrator.

Top module: `power_trip`

## Requirements
- R1: `sample_stb_o` is high for one cycle out of every `DIV` cycles, and the first strobe comes `DIV-1` clock edges after reset is released. The voltage and current inputs are captured on each clock edge where the strobe is high.
- R2: Every `WIN` consecutive captured pairs form one window, and windows follow each other with no gaps. `power_vld_o` pulses high for exactly one cycle per window, no later than `WIN+4` cycles after the edge that captured the window's last pair.
- R3: Each channel's bias is the floor of the sum of its `WIN` raw samples in that window divided by `WIN`. The bias is subtracted from every sample of that channel in the same window before any multiplication, so a constant offset on either channel has no effect on power.
- R4: `power_o` is a signed 32-bit value equal to floor((T * `scale_i`) / 2^`SHIFT`). Here T is the sum over the window of the bias-corrected voltage times the bias-corrected current, divided by `WIN` and truncated toward zero. The sign of the result follows the sign of the correlation, so anti-phase signals give negative power.
- R5: On the cycle after a `power_vld_o` pulse whose `power_o` is strictly greater than the signed `limit_i`, `trip_o` is high. A power equal to the limit, or below it, does not trip.
- R6: Once high, `trip_o` stays high through later windows of any power. It falls one cycle after `clear_i` is sampled high, or at once when `rst_ni` is asserted. A trip being set takes priority over a clear in the same cycle.
- R7: `power_o` holds its value in every cycle without a valid pulse.
- R8: While `rst_ni` is low, `sample_stb_o`, `power_vld_o`, `trip_o` and `power_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| v_smp_i | input | 12 | Voltage converter reading, unsigned |
| i_smp_i | input | 12 | Current converter reading, unsigned |
| limit_i | input | 32 | Signed power limit, same units as `power_o` |
| scale_i | input | 16 | Unsigned fixed-point power scale, `SHIFT` fraction bits |
| clear_i | input | 1 | Synchronous clear of the latched trip |
| sample_stb_o | output | 1 | Sampling strobe sent to the converters |
| power_o | output | 32 | Signed active power of the last finished window |
| power_vld_o | output | 1 | One-cycle pulse when `power_o` updates |
| trip_o | output | 1 | Latched overload trip to the relay driver |

## Verification
The bench puts different constant offsets on the two channels. A design that skips or misplaces the bias subtraction then reports large power where none exists. One window has a non-integer raw mean, which exposes a bias that rounds instead of taking the floor. Anti-phase drive checks that power is signed and does not trip, and a power exactly equal to the limit checks that a `>=` comparison is caught. After an overload, a later low-power window must leave the trip set, and only `clear_i` may drop it. Several windows run back to back, so a design that mixes up its banks or loses a strobe at a window edge computes from the wrong samples.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int SMP_W   = 12;
  localparam int PWR_W   = 32;
  localparam int SCALE_W = 16;

  typedef logic [SMP_W-1:0]        smp_t;
  typedef logic signed [PWR_W-1:0] pwr_t;
endpackage

// File: rtl/pt_strobe.sv
module pt_strobe #(
  parameter int DIV = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic stb_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap  = (cnt_q == CW'(DIV - 1));
  assign stb_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pt_capture.sv
module pt_capture
  import pt_pkg::*;
#(
  parameter int WIN = 200
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  stb_i,
  input  logic [1:0][SMP_W-1:0] smp_i,
  input  logic                  rd_bank_i,
  input  logic [$clog2(WIN)-1:0] rd_idx_i,
  output logic [1:0][SMP_W-1:0] rd_o,
  output logic [1:0][SMP_W-1:0] bias_o,
  output logic                  done_o,
  output logic                  done_bank_o
);
  localparam int IW = $clog2(WIN);
  localparam int SW = SMP_W + $clog2(WIN + 1);

  logic [IW-1:0] widx_q;
  logic          bank_q;
  logic          done_q;
  logic          last;

  assign last        = (widx_q == IW'(WIN - 1));
  assign done_o      = done_q;
  assign done_bank_o = ~bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      widx_q <= '0;
      bank_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= stb_i && last;
      if (stb_i) begin
        widx_q <= last ? '0 : widx_q + 1'b1;
        if (last) bank_q <= ~bank_q;
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [SMP_W-1:0] mem [2][WIN];
    logic [SW-1:0]    sum_q;
    logic [SW-1:0]    sum_nxt;
    logic [SMP_W-1:0] bias_q;

    assign sum_nxt = sum_q + SW'(smp_i[c]);

    always_ff @(posedge clk_i) begin
      if (stb_i) mem[bank_q][widx_q] <= smp_i[c];
    end

    // first pass: raw sum, bias fixed when the window closes
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_q  <= '0;
        bias_q <= '0;
      end else if (stb_i) begin
        if (last) begin
          sum_q  <= '0;
          bias_q <= SMP_W'(sum_nxt / SW'(WIN));
        end else begin
          sum_q  <= sum_nxt;
        end
      end
    end

    assign rd_o[c]   = mem[rd_bank_i][rd_idx_i];
    assign bias_o[c] = bias_q;
  end
endmodule

// File: rtl/pt_power.sv
module pt_power
  import pt_pkg::*;
#(
  parameter int WIN   = 200,
  parameter int SHIFT = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   bank_i,
  input  logic [1:0][SMP_W-1:0]  bias_i,
  input  logic [1:0][SMP_W-1:0]  rd_i,
  input  logic [SCALE_W-1:0]     scale_i,
  output logic                   rd_bank_o,
  output logic [$clog2(WIN)-1:0] rd_idx_o,
  output pwr_t                   power_o,
  output logic                   vld_o
);
  localparam int IW  = $clog2(WIN);
  localparam int CW  = SMP_W + 1;
  localparam int PRW = 2 * CW;
  localparam int AW  = PRW + $clog2(WIN) + 1;
  localparam int MW  = AW + SCALE_W + 1;
  localparam logic signed [AW-1:0] WIN_S = AW'(WIN);

  logic                  busy_q, fin_q, vld_q, rbank_q;
  logic [IW-1:0]         idx_q;
  logic signed [AW-1:0]  acc_q;
  logic signed [CW-1:0]  dv, di;
  logic signed [PRW-1:0] prod;
  logic signed [AW-1:0]  mean;
  logic signed [MW-1:0]  scaled, shifted;
  pwr_t                  power_q;
  logic                  at_end;

  // second pass: bias removed before the multiply
  assign dv      = $signed({1'b0, rd_i[0]}) - $signed({1'b0, bias_i[0]});
  assign di      = $signed({1'b0, rd_i[1]}) - $signed({1'b0, bias_i[1]});
  assign prod    = PRW'(dv) * PRW'(di);
  assign mean    = acc_q / WIN_S;
  assign scaled  = MW'(mean) * MW'($signed({1'b0, scale_i}));
  assign shifted = scaled >>> SHIFT;
  assign at_end  = (idx_q == IW'(WIN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      fin_q   <= 1'b0;
      vld_q   <= 1'b0;
      rbank_q <= 1'b0;
      idx_q   <= '0;
      acc_q   <= '0;
      power_q <= '0;
    end else begin
      fin_q <= busy_q && at_end;
      vld_q <= fin_q;
      if (fin_q) power_q <= pwr_t'(shifted);
      if (start_i) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        acc_q   <= '0;
        rbank_q <= bank_i;
      end else if (busy_q) begin
        acc_q <= acc_q + AW'(prod);
        if (at_end) busy_q <= 1'b0;
        else        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign rd_bank_o = rbank_q;
  assign rd_idx_o  = idx_q;
  assign power_o   = power_q;
  assign vld_o     = vld_q;
endmodule

// File: rtl/power_trip.sv
module power_trip
  import pt_pkg::*;
#(
  parameter int DIV   = 8000,
  parameter int WIN   = 200,
  parameter int SHIFT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [11:0]        v_smp_i,
  input  logic [11:0]        i_smp_i,
  input  logic signed [31:0] limit_i,
  input  logic [15:0]        scale_i,
  input  logic               clear_i,
  output logic               sample_stb_o,
  output logic signed [31:0] power_o,
  output logic               power_vld_o,
  output logic               trip_o
);
  localparam int IW = $clog2(WIN);

  logic                  stb, done, done_bank, rd_bank, vld;
  logic [IW-1:0]         rd_idx;
  logic [1:0][SMP_W-1:0] smp, rd, bias;
  pwr_t                  power;
  logic                  trip_q;

  assign smp = {i_smp_i, v_smp_i};

  pt_strobe #(.DIV(DIV)) i_strobe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_o (stb)
  );

  pt_capture #(.WIN(WIN)) i_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (stb),
    .smp_i      (smp),
    .rd_bank_i  (rd_bank),
    .rd_idx_i   (rd_idx),
    .rd_o       (rd),
    .bias_o     (bias),
    .done_o     (done),
    .done_bank_o(done_bank)
  );

  pt_power #(.WIN(WIN), .SHIFT(SHIFT)) i_power (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (done),
    .bank_i   (done_bank),
    .bias_i   (bias),
    .rd_i     (rd),
    .scale_i  (scale_i),
    .rd_bank_o(rd_bank),
    .rd_idx_o (rd_idx),
    .power_o  (power),
    .vld_o    (vld)
  );

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      trip_q <= 1'b0;
    else if (vld && (power > limit_i)) trip_q <= 1'b1;
    else if (clear_i)                 trip_q <= 1'b0;
  end

  assign sample_stb_o = stb;
  assign power_o      = power;
  assign power_vld_o  = vld;
  assign trip_o       = trip_q;
endmodule

// File: rtl/power_trip_chk.sv
module power_trip_chk (
  input logic               clk_i,
  input logic               rst_ni,
  input logic signed [31:0] limit_i,
  input logic               clear_i,
  input logic               sample_stb_o,
  input logic signed [31:0] power_o,
  input logic               power_vld_o,
  input logic               trip_o
);
  // R1
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_stb_o |=> !sample_stb_o);

  // R2
  vld_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_vld_o |=> !power_vld_o);

  // R5
  overload_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (power_vld_o && (power_o > limit_i)) |=> trip_o);

  // R5
  trip_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_o) |-> $past(power_vld_o));

  // R6
  trip_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && !clear_i) |=> trip_o);

  // R7
  power_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !power_vld_o |-> $stable(power_o));
endmodule

bind power_trip power_trip_chk i_power_trip_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .limit_i     (limit_i),
  .clear_i     (clear_i),
  .sample_stb_o(sample_stb_o),
  .power_o     (power_o),
  .power_vld_o (power_vld_o),
  .trip_o      (trip_o)
);

// File: tb/test_power_trip.sv
module test_power_trip;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 48;
  localparam int WIN   = 20;
  localparam int SHIFT = 8;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [11:0]        v_smp = '0, i_smp = '0;
  logic signed [31:0] limit = 32'sd1000;
  logic [15:0]        scale = 16'd256;
  logic               clear = 1'b0;
  logic               stb, vld, trip;
  logic signed [31:0] power;

  int n_chk = 0, n_bad = 0;
  longint exp_p = 0;
  bit exp_trip = 1'b0;
  longint gap_meas = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  power_trip #(.DIV(DIV), .WIN(WIN), .SHIFT(SHIFT)) i_power_trip (
    .clk_i(clk), .rst_ni(rst_ni), .v_smp_i(v_smp), .i_smp_i(i_smp),
    .limit_i(limit), .scale_i(scale), .clear_i(clear),
    .sample_stb_o(stb), .power_o(power), .power_vld_o(vld), .trip_o(trip));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // mode 0: in phase square, 1: anti-phase square, 2: ramp against period-3 steps
  task automatic feed_window(input int mode, input int dv, input int av, input int di, input int ai);
    longint vs [WIN];
    longint is [WIN];
    longint sv, si, bv, bi, acc, mean, t0;
    sv = 0; si = 0; acc = 0; t0 = 0;
    for (int k = 0; k < WIN; k++) begin
      int v, c;
      case (mode)
        0:       begin v = dv + ((k % 2) ? -av : av); c = di + ((k % 2) ? -ai : ai); end
        1:       begin v = dv + ((k % 2) ? -av : av); c = di + ((k % 2) ? ai : -ai); end
        default: begin v = dv + av * k;               c = di + ai * (k % 3); end
      endcase
      v_smp = 12'(v); i_smp = 12'(c);
      vs[k] = v; is[k] = c;
      do @(negedge clk); while (!stb);
      if (k == 1) gap_meas = ($time - t0) / CLK_PERIOD;
      t0 = $time;
      @(posedge clk); #1;
    end
    for (int k = 0; k < WIN; k++) begin sv += vs[k]; si += is[k]; end
    bv = sv / WIN; bi = si / WIN;
    for (int k = 0; k < WIN; k++) acc += (vs[k] - bv) * (is[k] - bi);
    mean  = acc / WIN;
    exp_p = (mean * longint'(scale)) >>> SHIFT;
    if (exp_p > longint'(limit)) exp_trip = 1'b1;
  endtask

  task automatic check_window(input string tag);
    int n = 0;
    longint held;
    @(negedge clk);
    while (!vld && n < 2 * WIN) begin @(negedge clk); n++; end
    chk(vld == 1'b1, {tag, " R2 valid pulse"}, longint'(vld), 1);
    chk(n <= WIN + 4, {tag, " R2 latency"}, n, WIN + 4);
    chk(longint'(power) == exp_p, {tag, " R4 power"}, longint'(power), exp_p);
    held = power;
    @(negedge clk);
    chk(vld == 1'b0, {tag, " R2 pulse width"}, longint'(vld), 0);
    chk(longint'(power) == held, {tag, " R7 hold"}, longint'(power), held);
    chk(trip == exp_trip, {tag, " R5/R6 trip"}, longint'(trip), longint'(exp_trip));
  endtask

  task automatic t_reset;
    #(3 * CLK_PERIOD);
    chk(stb == 0 && vld == 0 && trip == 0 && power == 0, "R8 reset outputs",
        longint'({stb, vld, trip}) + longint'(power), 0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_in_phase;
    feed_window(0, 2000, 100, 2048, 5);
    chk(gap_meas == DIV, "R1 strobe period", gap_meas, DIV);
    check_window("in-phase");
  endtask

  task automatic t_anti_phase;
    feed_window(1, 1500, 100, 2600, 20);
    chk(exp_p < 0, "R4 negative expected", exp_p, -2000);
    check_window("anti-phase");
  endtask

  task automatic t_dc_only;
    feed_window(0, 3500, 300, 3900, 0);
    check_window("R3 dc-only current");
  endtask

  task automatic t_ramp_bias;
    limit = 32'sd100000;
    feed_window(2, 1000, 7, 2000, 50);
    check_window("R3 floor bias ramp");
    limit = 32'sd1000;
  endtask

  task automatic t_equal_limit;
    feed_window(0, 2000, 100, 2048, 10);
    chk(exp_p == 1000, "R5 equal setup", exp_p, 1000);
    check_window("R5 equal to limit");
  endtask

  task automatic t_overload_sticky_clear;
    feed_window(0, 1800, 100, 1000, 20);
    check_window("R5 overload");
    feed_window(0, 1800, 100, 1000, 5);
    check_window("R6 sticky after low window");
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0; exp_trip = 1'b0;
    chk(trip == 1'b0, "R6 clear", longint'(trip), 0);
    feed_window(0, 2000, 100, 2048, 5);
    check_window("R6 after clear");
  endtask

  task automatic t_async_reset;
    feed_window(0, 1800, 100, 1000, 20);
    check_window("R5 overload again");
    @(negedge clk); #2;
    rst_ni = 1'b0; #1;
    chk(trip == 0 && power == 0 && vld == 0, "R6 R8 async reset",
        longint'(trip) + longint'(power), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_in_phase();
    t_anti_phase();
    t_dc_only();
    t_ramp_bias();
    t_equal_limit();
    t_overload_sticky_clear();
    t_async_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule